// File: doc/BRIEF.md
# Runt-Free Gated Clock Fanout

This block picks one of two clock sources, a main system clock or an auxiliary scan/test clock, and drives the result to a set of identical output pairs. Each pair has a true output and a complement output. One shared stop request can halt every output at once. It is sampled by a register that runs on the falling edge of the selected clock. Starting and stopping therefore only happen while the clock is already low, so no output ever produces a truncated high pulse.

The stop request is active high: holding it high parks every true output low. The source select chooses the main clock when low, and should be tied low when it is unused. The select is not made glitch-free. It should only be changed while the outputs are stopped. The reset is synchronous and active low, and it is sampled on the falling edge of the selected clock. While it is held, it puts the block into the stopped state.

Top module: `rgf_clk_fanout`

## Requirements
- R1: With `src_sel` low (code 0), the true outputs follow `main_clk` while running.
- R2: With `src_sel` high (code 1), the true outputs follow `aux_clk` while running, and `main_clk` has no effect on them.
- R3: `stop_req` is sampled only on a falling edge of the selected clock. A change made during a high phase leaves the outputs unchanged until that phase ends.
- R4: When the last sampled `stop_req` is low, every true output equals the selected clock level.
- R5: When `stop_req` is high at a falling edge of the selected clock, every true output stays low from that edge onward, until a later falling edge samples it low.
- R6: No true output high pulse is shorter than a full high phase of the selected clock. The stop state only changes while the selected clock is low.
- R7: All `NUM_PAIRS` true outputs (4 by default) carry the same value at all times.
- R8: Each complement output is the inverse of its true output, so a stopped pair shows true low and complement high.
- R9: `rst_n` low at a falling edge of the selected clock forces the stopped state. A high phase already under way is not cut short, and the outputs remain low until the first falling edge that samples `rst_n` high and `stop_req` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| main_clk | input | 1 | Main system clock source |
| aux_clk | input | 1 | Auxiliary scan/test clock source |
| src_sel | input | 1 | Source select: 0 main, 1 auxiliary |
| stop_req | input | 1 | Active-high request to park the outputs low |
| rst_n | input | 1 | Synchronous active-low reset, sampled on the selected clock's falling edge |
| q_t | output | NUM_PAIRS | True gated clock outputs |
| q_c | output | NUM_PAIRS | Complement gated clock outputs |

## Verification
The bench raises and lowers the stop request, and asserts reset, in the middle of a high phase. A design that applied these asynchronously would cut that phase short or begin a pulse mid-phase. That would appear as a level error half a phase later and as a short pulse in the width monitor. It switches to the auxiliary source and samples during a long auxiliary low phase, across several main-clock edges, to catch a mux that leaks or inverts the select. It also looks at every pair and its complement at each sample, to catch a fanout slice that is miswired or left un-inverted.

// File: rtl/rgf_pkg.sv
// Shared definitions for the runt-free gated clock fanout.
// Assumes: select code 0 is the main clock, code 1 the auxiliary clock.
package rgf_pkg;
    typedef enum logic {
        SRC_MAIN = 1'b0,
        SRC_AUX  = 1'b1
    } src_e;

    localparam int unsigned DEFAULT_PAIRS = 4;
endpackage

// File: rtl/rgf_src_mux.sv
// Source mux: routes the main or auxiliary clock to a single internal clock.
// Assumes: the select changes only while the downstream gate is stopped, so
// a glitch at the switch point never reaches the outputs.
module rgf_src_mux
    import rgf_pkg::*;
(
    input  logic main_clk,
    input  logic aux_clk,
    input  logic src_sel,
    output logic clk_o
);

    // Pick the active source; anything other than the aux code picks main.
    always_comb begin
        if (src_e'(src_sel) == SRC_AUX) begin
            clk_o = aux_clk;
        end else begin
            clk_o = main_clk;
        end
    end

endmodule

// File: rtl/rgf_stop_reg.sv
// Stop register: samples the stop request on the falling edge of the selected
// clock, so the gate only moves while that clock is low.
// Assumes: stop_req meets setup/hold around the falling edge; rst_n is a
// synchronous active-low reset that forces the stopped state.
module rgf_stop_reg (
    input  logic clk_i,
    input  logic rst_n,
    input  logic stop_req,
    output logic stop_q
);

    // Capture the stop request on the low-going clock edge.
    always_ff @(negedge clk_i) begin
        if (!rst_n) begin
            stop_q <= 1'b1;
        end else begin
            stop_q <= stop_req;
        end
    end

    AST_CAPTURE: assert property (@(negedge clk_i) disable iff (!rst_n)
        1'b1 |=> (stop_q == $past(stop_req)));                         // R3

    AST_RESET_STOP: assert property (@(negedge clk_i)
        !rst_n |=> stop_q);                                            // R9

endmodule

// File: rtl/rgf_fanout.sv
// Gate and fanout: ANDs the selected clock with the inverted stop state and
// drives NUM_PAIRS identical true/complement pairs.
// Assumes: stop_q only toggles while clk_i is low (falling-edge register).
module rgf_fanout #(
    parameter int unsigned NUM_PAIRS = 4
) (
    input  logic                 clk_i,
    input  logic                 stop_q,
    output logic [NUM_PAIRS-1:0] q_t,
    output logic [NUM_PAIRS-1:0] q_c
);

    localparam int unsigned LAST_PAIR = NUM_PAIRS - 1;

    logic gated;

    // Single gating point shared by all pairs, so every pair sees one edge.
    always_comb begin
        gated = clk_i & ~stop_q;
    end

    // One true/complement slice per output pair.
    for (genvar p = 0; p <= LAST_PAIR; p++) begin : g_pair
        always_comb begin
            q_t[p] = gated;
            q_c[p] = ~gated;
        end
    end

    // The stop state may only move while the clock is low.
    always @(stop_q) begin
        AST_STOP_MOVES_LOW: assert (clk_i !== 1'b1);                   // R6
    end

endmodule

// File: rtl/rgf_clk_fanout.sv
// Top of the runt-free gated clock fanout: source mux, falling-edge stop
// register and gated fanout to NUM_PAIRS output pairs.
// Assumes: src_sel is tied low when unused and is changed only while stopped.
module rgf_clk_fanout
    import rgf_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = DEFAULT_PAIRS
) (
    input  logic                 main_clk,
    input  logic                 aux_clk,
    input  logic                 src_sel,
    input  logic                 stop_req,
    input  logic                 rst_n,
    output logic [NUM_PAIRS-1:0] q_t,
    output logic [NUM_PAIRS-1:0] q_c
);

    logic sel_clk;
    logic stop_q;

    rgf_src_mux u_mux (
        .main_clk (main_clk),
        .aux_clk  (aux_clk),
        .src_sel  (src_sel),
        .clk_o    (sel_clk)
    );

    rgf_stop_reg u_stop (
        .clk_i    (sel_clk),
        .rst_n    (rst_n),
        .stop_req (stop_req),
        .stop_q   (stop_q)
    );

    rgf_fanout #(
        .NUM_PAIRS (NUM_PAIRS)
    ) u_fan (
        .clk_i  (sel_clk),
        .stop_q (stop_q),
        .q_t    (q_t),
        .q_c    (q_c)
    );

    AST_MAIN_ROUTE: assert property (@(negedge main_clk) disable iff (!rst_n)
        (src_sel == SRC_MAIN && !stop_q) |-> q_t[0]);                  // R1

    AST_AUX_ROUTE: assert property (@(negedge aux_clk) disable iff (!rst_n)
        (src_sel == SRC_AUX && !stop_q) |-> q_t[0]);                   // R2

    AST_OFF_LOW: assert property (@(negedge sel_clk) disable iff (!rst_n)
        stop_req |=> !q_t[0]);                                         // R5

endmodule

// File: tb/tb_rgf_clk_fanout.sv
`timescale 1ns/1ps
module tb_rgf_clk_fanout;
    localparam int  NP         = 4;
    localparam time CLK_PERIOD = 10;
    localparam time AUX_PERIOD = 26;

    logic          main_clk = 1'b0;
    logic          aux_clk  = 1'b0;
    logic          src_sel;
    logic          stop_req;
    logic          rst_n;
    logic [NP-1:0] q_t;
    logic [NP-1:0] q_c;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    rgf_clk_fanout #(.NUM_PAIRS(NP)) dut (
        .main_clk (main_clk),
        .aux_clk  (aux_clk),
        .src_sel  (src_sel),
        .stop_req (stop_req),
        .rst_n    (rst_n),
        .q_t      (q_t),
        .q_c      (q_c)
    );

    initial forever #(CLK_PERIOD/2) main_clk = ~main_clk;
    initial begin
        #3;
        forever #(AUX_PERIOD/2) aux_clk = ~aux_clk;
    end

    // Level check of every pair: R7 (pairs equal) and R8 (complement).
    task automatic expect_level(input bit exp, input string req);
        checks++;
        if (q_t !== {NP{exp}} || q_c !== {NP{~exp}}) begin
            errors++;
            $display("FAIL %s actual q_t=%b q_c=%b expected q_t=%b q_c=%b (R7/R8)",
                     req, q_t, q_c, {NP{exp}}, {NP{~exp}});
        end
    endtask

    task automatic main_high(); @(posedge main_clk); #2; endtask
    task automatic main_low();  @(negedge main_clk); #2; endtask
    task automatic aux_high();  @(posedge aux_clk);  #3; endtask
    task automatic aux_low();   @(negedge aux_clk);  #3; endtask

    // Pulse width monitor for R6.
    realtime rise_at;
    bit      rise_seen = 0;
    always @(posedge q_t[0]) begin
        rise_at   = $realtime;
        rise_seen = 1;
    end
    always @(negedge q_t[0]) begin
        if (rise_seen) begin
            realtime width, need;
            width = $realtime - rise_at;
            need  = src_sel ? AUX_PERIOD/2.0 : CLK_PERIOD/2.0;
            checks++;
            if (width < need - 0.01) begin
                errors++;
                $display("FAIL R6 runt pulse actual width=%0t expected >= %0t", width, need);
            end
        end
    end

    task automatic t_reset();
        rst_n = 1'b0; stop_req = 1'b0; src_sel = 1'b0;
        repeat (3) @(negedge main_clk);
        main_high(); expect_level(1'b0, "R9 held in reset");
        rst_n = 1'b1;
        #2;          expect_level(1'b0, "R9 no start mid-high after release");
        main_high(); expect_level(1'b1, "R9 runs after first falling edge");
    endtask

    task automatic t_follow_main();
        for (int i = 0; i < 4; i++) begin
            main_high(); expect_level(1'b1, "R4 R1 high phase");
            main_low();  expect_level(1'b0, "R4 R1 low phase");
        end
    endtask

    task automatic t_stop();
        main_high(); stop_req = 1'b1;
        #2;          expect_level(1'b1, "R3 R6 high phase not truncated");
        main_high(); expect_level(1'b0, "R5 parked low");
        main_low();  expect_level(1'b0, "R5 parked low phase");
        main_high(); expect_level(1'b0, "R5 stays parked");
    endtask

    task automatic t_start();
        main_high(); stop_req = 1'b0;
        #2;          expect_level(1'b0, "R3 R6 no mid-high start");
        main_high(); expect_level(1'b1, "R3 restarts after falling edge");
    endtask

    task automatic t_aux();
        main_high(); stop_req = 1'b1;
        main_high(); src_sel = 1'b1;
        repeat (2) @(negedge aux_clk);
        aux_high(); stop_req = 1'b0;
        #3;         expect_level(1'b0, "R6 aux no mid-high start");
        aux_high(); expect_level(1'b1, "R2 aux high phase");
        aux_low();  expect_level(1'b0, "R2 aux low phase");
        #5;         expect_level(1'b0, "R2 main edges ignored");
        aux_high(); expect_level(1'b1, "R2 aux high again");
        stop_req = 1'b1;
        aux_high(); expect_level(1'b0, "R5 aux parked");
        src_sel = 1'b0;
        repeat (2) @(negedge main_clk);
        main_high(); stop_req = 1'b0;
        main_high(); expect_level(1'b1, "R1 back on main");
        main_low();  expect_level(1'b0, "R1 back on main low");
    endtask

    task automatic t_reset_running();
        main_high(); rst_n = 1'b0;
        #2;          expect_level(1'b1, "R9 reset does not truncate");
        main_high(); expect_level(1'b0, "R9 reset parks outputs");
        rst_n = 1'b1;
        main_high(); expect_level(1'b1, "R9 resumes after release");
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_follow_main();
        t_stop();
        t_start();
        t_aux();
        t_reset_running();
        repeat (2) @(posedge main_clk);
        done = 1;
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end
endmodule